// File: doc/BRIEF.md
# ECC Error Logger with Write-One-to-Clear Status

This block records memory ECC error events for a DRAM controller. It has two event inputs, one for correctable errors and one for uncorrectable errors. Each event input has its own detail bus: a physical address, an 8-bit syndrome and a channel select. The block keeps one correctable flag and one uncorrectable flag. It also keeps a single set of captured details, shared by both kinds of error. Software reads all of this state through a small select-and-read interface.

Severity decides what the logger keeps. The first error after the flags are clear is captured. An uncorrectable error replaces correctable details that are already held. All other errors set their flag but leave the captured details as they are. Software clears a flag by writing a one to its bit. A command word enables, for each severity, a one-cycle system-error pulse. The pulse fires when the matching flag goes from clear to set.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, every readable register returns zero and `serr_pulse` is low.
- R2: A correctable event sets bit 0 of the status register (select 0). An uncorrectable event sets bit 7. All other status bits read as zero.
- R3: Writing select 0 with a 1 in bit 0 or bit 7 clears that flag. A 0 in either bit leaves that flag alone. If an event of the same kind arrives in the same cycle as the clear, the flag stays set and the event is handled as if the flag were clear.
- R4: The address register (select 1) holds bits 31:12 of the captured error address. Bits 11:0 read as zero.
- R5: The syndrome register (select 2) holds the captured 8-bit syndrome in bits 7:0.
- R6: The channel register (select 3) holds the captured channel in bit 0. All other bits read as zero.
- R7: With both flags clear, the next event captures its own address, syndrome and channel. A correctable event while either flag is set does not change the captured details. An uncorrectable event while the uncorrectable flag is set does not change them either.
- R8: An uncorrectable event while only the correctable flag is set overwrites the captured details with the uncorrectable event's details.
- R9: If a correctable and an uncorrectable event arrive in the same cycle and neither flag is held, both flags are set and the uncorrectable event's details are captured.
- R10: In the command register (select 4), bit 7 enables the pulse for correctable errors and bit 8 enables it for uncorrectable errors. Only these two bits can be written; all other bits read as zero.
- R11: `serr_pulse` goes high for exactly the one cycle after the clock edge at which a flag goes from clear to set, provided that flag's enable bit was 1 before that edge.
- R12: `reg_rdata` shows the register state as of the last clock edge for the current `reg_sel`. Selects 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_evt | input | 1 | Correctable error event, one cycle per error |
| ce_addr | input | 32 | Physical address of the correctable error |
| ce_syn | input | 8 | Syndrome of the correctable error |
| ce_chan | input | 1 | Channel of the correctable error |
| ue_evt | input | 1 | Uncorrectable error event, one cycle per error |
| ue_addr | input | 32 | Physical address of the uncorrectable error |
| ue_syn | input | 8 | Syndrome of the uncorrectable error |
| ue_chan | input | 1 | Channel of the uncorrectable error |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| serr_pulse | output | 1 | One-cycle system-error pulse |

## Verification
Internal state reaches the ports one cycle after the edge that changes it. A flag that was lost or left stuck shows on the next status read and on the presence or absence of `serr_pulse`. A wrong capture decision shows in the address, syndrome and channel reads right after the edge that should have loaded them, or should have left them unchanged. Random traffic switches `reg_sel` every cycle and mixes overlapping events with clears. This means a wrong severity ordering or an error in clear-versus-set priority surfaces within a few cycles.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  // register selects
  localparam logic [2:0] SEL_STS  = 3'd0;
  localparam logic [2:0] SEL_ADDR = 3'd1;
  localparam logic [2:0] SEL_SYN  = 3'd2;
  localparam logic [2:0] SEL_CHAN = 3'd3;
  localparam logic [2:0] SEL_CMD  = 3'd4;

  // severity index: 0 correctable, 1 uncorrectable
  localparam int NSEV = 2;
  localparam int SEV_CE = 0;
  localparam int SEV_UE = 1;

  // bit positions in status and command words
  localparam int STS_CE_BIT = 0;
  localparam int STS_UE_BIT = 7;
  localparam int CMD_CE_BIT = 7;
  localparam int CMD_UE_BIT = 8;
endpackage

// File: rtl/ecc_log_flags.sv
module ecc_log_flags
  import ecc_log_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSEV-1:0]  evt,
  input  logic             wr,
  input  logic [2:0]       sel,
  input  logic [REG_W-1:0] wdata,
  output logic [NSEV-1:0]  flag,
  output logic [NSEV-1:0]  held,
  output logic [NSEV-1:0]  fresh,
  output logic [NSEV-1:0]  en,
  output logic             serr
);
  logic [NSEV-1:0] flag_q, flag_d, en_q, en_d, clr;
  logic            serr_q, serr_d;

  for (genvar k = 0; k < NSEV; k++) begin : g_sev
    localparam int SP = (k == SEV_UE) ? STS_UE_BIT : STS_CE_BIT;
    localparam int CP = (k == SEV_UE) ? CMD_UE_BIT : CMD_CE_BIT;
    assign clr[k]    = wr && (sel == SEL_STS) && wdata[SP];
    assign held[k]   = flag_q[k] & ~clr[k];
    assign fresh[k]  = evt[k] & ~held[k];
    assign flag_d[k] = held[k] | evt[k];
    assign en_d[k]   = (wr && (sel == SEL_CMD)) ? wdata[CP] : en_q[k];
  end

  always_comb begin
    serr_d = |(fresh & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      serr_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
      serr_q <= serr_d;
    end
  end

  assign flag = flag_q;
  assign en   = en_q;
  assign serr = serr_q;

  a_r2_ce_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt[SEV_CE] |=> flag[SEV_CE]);
  a_r2_ue_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt[SEV_UE] |=> flag[SEV_UE]);
  a_r3_ce_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_STS && wdata[STS_CE_BIT] && !evt[SEV_CE]) |=> !flag[SEV_CE]);
  a_r11_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    serr |-> (($past(evt[SEV_CE]) && $past(en[SEV_CE]) && flag[SEV_CE]) ||
              ($past(evt[SEV_UE]) && $past(en[SEV_UE]) && flag[SEV_UE])));
endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture #(
  parameter int ADDR_W = 32,
  parameter int GRAIN  = 12,
  parameter int SYN_W  = 8,
  localparam int BLK_W = ADDR_W - GRAIN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              pick_ue,
  input  logic [ADDR_W-1:0] ce_addr,
  input  logic [SYN_W-1:0]  ce_syn,
  input  logic              ce_chan,
  input  logic [ADDR_W-1:0] ue_addr,
  input  logic [SYN_W-1:0]  ue_syn,
  input  logic              ue_chan,
  output logic [BLK_W-1:0]  blk,
  output logic [SYN_W-1:0]  syn,
  output logic              chan
);
  logic [BLK_W-1:0] blk_q, blk_d;
  logic [SYN_W-1:0] syn_q, syn_d;
  logic             chan_q, chan_d;

  always_comb begin
    blk_d  = blk_q;
    syn_d  = syn_q;
    chan_d = chan_q;
    if (load) begin
      if (pick_ue) begin
        blk_d  = ue_addr[ADDR_W-1:GRAIN];
        syn_d  = ue_syn;
        chan_d = ue_chan;
      end else begin
        blk_d  = ce_addr[ADDR_W-1:GRAIN];
        syn_d  = ce_syn;
        chan_d = ce_chan;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q  <= '0;
      syn_q  <= '0;
      chan_q <= 1'b0;
    end else if (load) begin
      blk_q  <= blk_d;
      syn_q  <= syn_d;
      chan_q <= chan_d;
    end
  end

  assign blk  = blk_q;
  assign syn  = syn_q;
  assign chan = chan_q;

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(blk) && $stable(syn) && $stable(chan)));
  a_r8_ue_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (load && pick_ue) |=> (blk == $past(ue_addr[ADDR_W-1:GRAIN]) && syn == $past(ue_syn)));
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int GRAIN  = 12,
  parameter int SYN_W  = 8,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_evt,
  input  logic [ADDR_W-1:0] ce_addr,
  input  logic [SYN_W-1:0]  ce_syn,
  input  logic              ce_chan,
  input  logic              ue_evt,
  input  logic [ADDR_W-1:0] ue_addr,
  input  logic [SYN_W-1:0]  ue_syn,
  input  logic              ue_chan,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              serr_pulse
);
  localparam int BLK_W = ADDR_W - GRAIN;

  logic [NSEV-1:0]  flag, held, fresh, en;
  logic             load, pick_ue;
  logic [BLK_W-1:0] blk;
  logic [SYN_W-1:0] syn;
  logic             chan;

  ecc_log_flags #(.REG_W(REG_W)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   ({ue_evt, ce_evt}),
    .wr    (reg_wr),
    .sel   (reg_sel),
    .wdata (reg_wdata),
    .flag  (flag),
    .held  (held),
    .fresh (fresh),
    .en    (en),
    .serr  (serr_pulse)
  );

  // severity ordering: a new uncorrectable wins; a correctable loads only
  // when nothing is held and no uncorrectable arrives alongside it
  always_comb begin
    pick_ue = fresh[SEV_UE];
    load    = fresh[SEV_UE] |
              (fresh[SEV_CE] & ~ue_evt & ~held[SEV_UE]);
  end

  ecc_log_capture #(.ADDR_W(ADDR_W), .GRAIN(GRAIN), .SYN_W(SYN_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .pick_ue (pick_ue),
    .ce_addr (ce_addr),
    .ce_syn  (ce_syn),
    .ce_chan (ce_chan),
    .ue_addr (ue_addr),
    .ue_syn  (ue_syn),
    .ue_chan (ue_chan),
    .blk     (blk),
    .syn     (syn),
    .chan    (chan)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_STS: begin
        reg_rdata[STS_CE_BIT] = flag[SEV_CE];
        reg_rdata[STS_UE_BIT] = flag[SEV_UE];
      end
      SEL_ADDR: reg_rdata = REG_W'({blk, {GRAIN{1'b0}}});
      SEL_SYN:  reg_rdata = REG_W'(syn);
      SEL_CHAN: reg_rdata = REG_W'(chan);
      SEL_CMD: begin
        reg_rdata[CMD_CE_BIT] = en[SEV_CE];
        reg_rdata[CMD_UE_BIT] = en[SEV_UE];
      end
      default: reg_rdata = '0;
    endcase
  end

  a_r9_both_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_evt && ue_evt) |=> (flag[SEV_CE] && flag[SEV_UE]));
  a_r7_ce_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_evt && !ue_evt && held[SEV_UE]) |-> !load);
endmodule

// File: tb/ecc_err_log_test.sv
module ecc_err_log_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_evt, ue_evt, ce_chan, ue_chan, reg_wr;
  logic [31:0] ce_addr, ue_addr, reg_wdata, reg_rdata;
  logic [7:0]  ce_syn, ue_syn;
  logic [2:0]  reg_sel;
  logic        serr_pulse;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model of the register state
  bit        m_ce, m_ue, m_chan, m_serr;
  bit [31:0] m_addr;
  bit [7:0]  m_syn;
  bit [1:0]  m_en;

  always #5 clk = ~clk;

  ecc_err_log uut (
    .clk(clk), .rst_n(rst_n),
    .ce_evt(ce_evt), .ce_addr(ce_addr), .ce_syn(ce_syn), .ce_chan(ce_chan),
    .ue_evt(ue_evt), .ue_addr(ue_addr), .ue_syn(ue_syn), .ue_chan(ue_chan),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .serr_pulse(serr_pulse)
  );

  function automatic bit [31:0] exp_read(input bit [2:0] s);
    bit [31:0] v = '0;
    case (s)
      3'd0: begin v[0] = m_ce; v[7] = m_ue; end
      3'd1: v = {m_addr[31:12], 12'h000};
      3'd2: v = {24'h0, m_syn};
      3'd3: v = {31'h0, m_chan};
      3'd4: begin v[7] = m_en[0]; v[8] = m_en[1]; end
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic string tag_of(input bit [2:0] s);
    case (s)
      3'd0: return "R2/R3 status";
      3'd1: return "R4 address";
      3'd2: return "R5 syndrome";
      3'd3: return "R6 channel";
      3'd4: return "R10 command";
      default: return "R12 unused select";
    endcase
  endfunction

  task automatic chk(input string tag, input bit [31:0] act, input bit [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle at a negedge, advance the model, check at the next negedge
  task automatic step(input bit ce, input bit ue, input bit wr, input bit [2:0] s,
                      input bit [31:0] wd, input bit [31:0] ca, input bit [7:0] cs,
                      input bit cc, input bit [31:0] ua, input bit [7:0] us,
                      input bit uc, input string tag);
    bit clr_ce, clr_ue, hce, hue, fce, fue;
    ce_evt = ce; ue_evt = ue; reg_wr = wr; reg_sel = s; reg_wdata = wd;
    ce_addr = ca; ce_syn = cs; ce_chan = cc;
    ue_addr = ua; ue_syn = us; ue_chan = uc;
    clr_ce = wr && s == 3'd0 && wd[0];
    clr_ue = wr && s == 3'd0 && wd[7];
    hce = m_ce && !clr_ce;
    hue = m_ue && !clr_ue;
    fce = ce && !hce;
    fue = ue && !hue;
    m_serr = (fce && m_en[0]) || (fue && m_en[1]);
    if (fue) begin
      m_addr = ua; m_syn = us; m_chan = uc;
    end else if (fce && !ue && !hue) begin
      m_addr = ca; m_syn = cs; m_chan = cc;
    end
    m_ce = hce || ce;
    m_ue = hue || ue;
    if (wr && s == 3'd4) m_en = {wd[8], wd[7]};
    @(negedge clk);
    chk("R11 serr_pulse", {31'h0, serr_pulse}, {31'h0, m_serr});
    chk(tag, reg_rdata, exp_read(s));
  endtask

  task automatic idle_read(input bit [2:0] s, input string tag);
    step(0, 0, 0, s, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0;
    ce_evt = 0; ue_evt = 0; reg_wr = 0; reg_sel = 0; reg_wdata = 0;
    ce_addr = 0; ce_syn = 0; ce_chan = 0; ue_addr = 0; ue_syn = 0; ue_chan = 0;
    m_ce = 0; m_ue = 0; m_chan = 0; m_serr = 0; m_addr = 0; m_syn = 0; m_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int s = 0; s < 8; s++) idle_read(3'(s), "R1 reset value");

    // R10: only enable bits are writable
    step(0, 0, 1, 3'd4, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, "R10 command mask");
    step(0, 0, 1, 3'd4, 32'h0000_0180, 0, 0, 0, 0, 0, 0, "R10 command write");
    // R7: first correctable captured, R4 low bits zero, R11 pulse
    step(1, 0, 0, 3'd1, 0, 32'h1234_5ABC, 8'h5A, 1, 0, 0, 0, "R4 first CE address");
    idle_read(3'd2, "R5 syndrome captured");
    idle_read(3'd3, "R6 channel captured");
    idle_read(3'd0, "R2 CE flag");
    step(1, 0, 0, 3'd1, 0, 32'h9999_9000, 8'h11, 0, 0, 0, 0, "R7 second CE ignored");
    // R8: uncorrectable overwrites correctable details
    step(0, 1, 0, 3'd1, 0, 0, 0, 0, 32'hCAFE_1FFF, 8'hE7, 0, "R8 UE overwrites");
    idle_read(3'd2, "R8 UE syndrome");
    step(1, 0, 0, 3'd1, 0, 32'h0BAD_0000, 8'h22, 1, 0, 0, 0, "R7 CE under UE ignored");
    step(0, 1, 0, 3'd2, 0, 0, 0, 0, 32'h7777_7000, 8'h33, 1, "R7 UE under UE ignored");
    // R3: write-one clears, zero leaves
    step(0, 0, 1, 3'd0, 32'h0000_FF7E, 0, 0, 0, 0, 0, 0, "R3 zero bits leave flags");
    step(0, 0, 1, 3'd0, 32'h0000_0081, 0, 0, 0, 0, 0, 0, "R3 clear both");
    // R9: simultaneous events
    step(1, 1, 0, 3'd0, 0, 32'h1111_1000, 8'h01, 0, 32'h2222_2000, 8'h02, 1, "R9 both flags");
    idle_read(3'd1, "R9 UE address wins");
    // R3: clear and new event in the same cycle
    step(0, 0, 1, 3'd0, 32'h0000_0081, 0, 0, 0, 0, 0, 0, "R3 clear before reuse");
    step(1, 0, 0, 3'd1, 0, 32'h4444_4000, 8'h44, 0, 0, 0, 0, "R7 CE after clear");
    step(1, 0, 1, 3'd0, 32'h0000_0001, 32'h5555_5000, 8'h55, 1, 0, 0, 0, "R3 clear with new CE");
    idle_read(3'd1, "R3 new CE captured");

    for (int i = 0; i < 4000; i++) begin
      bit [2:0] s = 3'($urandom % 8);
      bit wr = ($urandom % 4) == 0;
      bit [31:0] wd = $urandom;
      step(($urandom % 4) == 0, ($urandom % 7) == 0, wr, s, wd,
           $urandom, 8'($urandom), 1'($urandom), $urandom, 8'($urandom),
           1'($urandom), tag_of(s));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule